// File: doc/BRIEF.md
# Serial Programming Session Sequencer

This block is the host side of an in-system flash programming link to a small microcontroller. It drives the target's serial clock, data-out and reset lines and reads its data-in line. After its own reset it brings the target up in a fixed order. First the target reset and the clock are held low. Then the target reset gets a timed high pulse, and a settle delay follows. Then the block sends the four-byte programming-enable instruction. The target proves it is in step by echoing the second enable byte while the third is being shifted. When that echo is wrong, the block still finishes the instruction, pulses the target reset again and retries, up to a retry limit.

Once the link is in sync, the block takes flash commands from a valid/ready stream. A load-word command becomes two instructions, low byte first and then high byte. A page-write command becomes one instruction and is followed by a fixed wait before anything else goes out. An end command releases the target reset so the target runs its new program. `cmd_ready` is high only when the sequencer is idle and synchronised. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The source must hold the command fields steady while `cmd_valid` is high and `cmd_ready` is low. While an instruction or a write wait is in progress, `cmd_ready` stays low and nothing is accepted.

All timing is counted in system clocks. `HALF_DIV` sets each serial clock phase. `RST_CYC`, `SETTLE_CYC` and `WRITE_CYC` set the reset pulse, the settle delay and the page write wait.

Top module: `serprog_host`

## Requirements
- R1: After reset both `tgt_rst` and `tgt_sck` are low. Each high pulse of `tgt_rst` lasts at least `RST_CYC` system clocks, and `tgt_sck` is low whenever `tgt_rst` is high.
- R2: After every falling edge of `tgt_rst`, at least `SETTLE_CYC` system clocks pass before the next rising edge of `tgt_sck`.
- R3: Every instruction is exactly 32 rising edges of `tgt_sck`, sent most significant bit first. `tgt_mosi` changes only while `tgt_sck` is low, and `tgt_miso` is sampled on each rising edge.
- R4: Inside an instruction, every high phase and every low phase between rising edges of `tgt_sck` lasts exactly `HALF_DIV` system clocks.
- R5: The enable instruction is bytes 0xAC 0x53 0x00 0x00. The byte read back while byte three is shifted is compared with 0x53. On a match, `sync_ok` goes high. All four bytes are always sent.
- R6: On an echo mismatch, `retry_cnt` increments by one, `tgt_rst` is pulsed again, and the settle delay and the enable instruction are repeated. `retry_cnt` never exceeds `MAX_RETRY`.
- R7: When `retry_cnt` reaches `MAX_RETRY`, `sync_fail` goes high and stays high. After that `tgt_sck` stays low, `cmd_ready` and `busy` stay low, and no further instruction is sent.
- R8: `cmd_ready` is high only when `sync_ok` is high and the block is neither busy nor done. A command is taken only on an edge where `cmd_valid` and `cmd_ready` are both high.
- R9: A load-word command (`cmd_kind`=0) sends 0x40 0x00 {000, addr[4:0]} word[7:0] and then 0x48 0x00 {000, addr[4:0]} word[15:8], in that order.
- R10: A page-write command (`cmd_kind`=1) sends 0x4C {0000, addr[11:8]} {addr[7:5], 00000} 0x00.
- R11: After the last falling edge of a page-write instruction, `tgt_sck` does not rise for at least `WRITE_CYC` system clocks.
- R12: An end command (`cmd_kind`=2) drives `tgt_rst` high and sets `done`. After that `busy` is low, `tgt_sck` stays low and no instruction is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| cmd_valid | input | 1 | Command offered on the stream |
| cmd_ready | output | 1 | Sequencer can take a command this cycle |
| cmd_kind | input | 2 | 0 load word, 1 page write, 2 end session, 3 accepted and discarded |
| cmd_addr | input | ADDR_W | Flash word address |
| cmd_word | input | 16 | Flash data word for a load |
| tgt_sck | output | 1 | Serial clock to the target, idle low |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_miso | input | 1 | Serial data from the target |
| tgt_rst | output | 1 | Target reset line, high means released or pulsed |
| sync_ok | output | 1 | Enable echo matched |
| sync_fail | output | 1 | Retry limit reached, sequence halted |
| retry_cnt | output | RETRY_W | Number of failed enable attempts |
| busy | output | 1 | Bring-up, instruction or write wait in progress |
| done | output | 1 | Session closed and target released |

## Verification
If the phase divider or the bit counter is wrong, it shows at once in the next instruction: an SCK phase is too short or too long, or an instruction does not have 32 bits. If the echo check looks at the wrong byte, `sync_ok`, `retry_cnt` or the count of reset pulses is wrong when the first enable finishes. A wrong field layout or byte order in the command path changes a captured instruction word during the first load or page write. A write timer that ends too early shortens the gap after that page write.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  // instruction opcodes and the enable key that the target echoes
  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] EN_KEY     = 8'h53;
  localparam logic [7:0] OP_LOAD_LO = 8'h40;
  localparam logic [7:0] OP_LOAD_HI = 8'h48;
  localparam logic [7:0] OP_WR_PAGE = 8'h4C;

  localparam logic [1:0] KIND_LOAD = 2'd0;
  localparam logic [1:0] KIND_PAGE = 2'd1;
  localparam logic [1:0] KIND_END  = 2'd2;

  typedef enum logic [3:0] {
    ST_POWER, ST_PULSE, ST_SETTLE, ST_ENABLE, ST_IDLE,
    ST_LOAD_LO, ST_LOAD_HI, ST_PAGE, ST_WWAIT, ST_DONE, ST_FAIL
  } seq_state_t;

endpackage

// File: rtl/serprog_timer.sv
module serprog_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] frame,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        fin,
  output logic [7:0]  echo
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div;
  logic [5:0]    ph;       // even: low phase, odd: high phase
  logic          active;
  logic [31:0]   tx;
  logic [15:0]   rx;       // last two received bytes

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0; ph <= '0; active <= 1'b0; tx <= '0; rx <= '0;
      sck <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        tx <= frame; active <= 1'b1; div <= '0; ph <= '0; sck <= 1'b0;
      end else if (active) begin
        if (div == DW'(HALF_DIV - 1)) begin
          div <= '0;
          if (!ph[0]) begin
            sck <= 1'b1;
            rx  <= {rx[14:0], miso};
          end else begin
            sck <= 1'b0;
            tx  <= {tx[30:0], 1'b0};
          end
          if (ph == 6'd63) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end
          ph <= ph + 6'd1;
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  assign mosi = tx[31];
  assign echo = rx[15:8];   // byte seen while the third byte was shifted
endmodule

// File: rtl/serprog_host.sv
module serprog_host
  import serprog_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int RST_CYC    = 8,
  parameter int SETTLE_CYC = 64,
  parameter int WRITE_CYC  = 100,
  parameter int MAX_RETRY  = 8,
  parameter int ADDR_W     = 12,
  parameter int PAGE_LSB   = 5,
  localparam int RETRY_W   = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_kind,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [15:0]        cmd_word,
  output logic               tgt_sck,
  output logic               tgt_mosi,
  input  logic               tgt_miso,
  output logic               tgt_rst,
  output logic               sync_ok,
  output logic               sync_fail,
  output logic [RETRY_W-1:0] retry_cnt,
  output logic               busy,
  output logic               done
);
  localparam int T_A  = (SETTLE_CYC > WRITE_CYC) ? SETTLE_CYC : WRITE_CYC;
  localparam int TMAX = (T_A > RST_CYC) ? T_A : RST_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_t        state;
  logic              ent;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       word_q;

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          sh_start, sh_fin;
  logic [31:0]   frame;
  logic [7:0]    sh_echo;

  // delay for each timed state
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_POWER:  begin tmr_load = ent; tmr_val = TW'(RST_CYC);    end
      ST_PULSE:  begin tmr_load = ent; tmr_val = TW'(RST_CYC);    end
      ST_SETTLE: begin tmr_load = ent; tmr_val = TW'(SETTLE_CYC); end
      ST_WWAIT:  begin tmr_load = ent; tmr_val = TW'(WRITE_CYC);  end
      default:   ;
    endcase
  end

  // instruction for each shifting state
  always_comb begin
    sh_start = 1'b0;
    frame    = '0;
    unique case (state)
      ST_ENABLE:  begin sh_start = ent; frame = {OP_ENABLE, EN_KEY, 16'h0000}; end
      ST_LOAD_LO: begin
        sh_start = ent;
        frame = {OP_LOAD_LO, 8'h00, 8'(addr_q[PAGE_LSB-1:0]), word_q[7:0]};
      end
      ST_LOAD_HI: begin
        sh_start = ent;
        frame = {OP_LOAD_HI, 8'h00, 8'(addr_q[PAGE_LSB-1:0]), word_q[15:8]};
      end
      ST_PAGE: begin
        sh_start = ent;
        frame = {OP_WR_PAGE, 16'({addr_q[ADDR_W-1:PAGE_LSB], PAGE_LSB'(0)}), 8'h00};
      end
      default: ;
    endcase
  end

  serprog_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
  );

  serprog_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .frame(frame), .miso(tgt_miso),
    .sck(tgt_sck), .mosi(tgt_mosi), .fin(sh_fin), .echo(sh_echo)
  );

  wire wait_over = !ent && tmr_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_POWER; ent <= 1'b1;
      retry_cnt <= '0; sync_ok <= 1'b0; sync_fail <= 1'b0; done <= 1'b0;
      addr_q <= '0; word_q <= '0;
    end else begin
      ent <= 1'b0;
      unique case (state)
        ST_POWER:  if (wait_over) begin state <= ST_PULSE;  ent <= 1'b1; end
        ST_PULSE:  if (wait_over) begin state <= ST_SETTLE; ent <= 1'b1; end
        ST_SETTLE: if (wait_over) begin state <= ST_ENABLE; ent <= 1'b1; end
        ST_ENABLE: if (sh_fin) begin
          if (sh_echo == EN_KEY) begin
            sync_ok <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            retry_cnt <= retry_cnt + 1'b1;
            if (retry_cnt == RETRY_W'(MAX_RETRY - 1)) begin
              sync_fail <= 1'b1;
              state     <= ST_FAIL;
            end else begin
              state <= ST_PULSE; ent <= 1'b1;
            end
          end
        end
        ST_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          word_q <= cmd_word;
          ent    <= 1'b1;
          case (cmd_kind)
            KIND_LOAD: state <= ST_LOAD_LO;
            KIND_PAGE: state <= ST_PAGE;
            KIND_END:  begin state <= ST_DONE; done <= 1'b1; end
            default:   state <= ST_IDLE;
          endcase
        end
        ST_LOAD_LO: if (sh_fin) begin state <= ST_LOAD_HI; ent <= 1'b1; end
        ST_LOAD_HI: if (sh_fin) state <= ST_IDLE;
        ST_PAGE:    if (sh_fin) begin state <= ST_WWAIT; ent <= 1'b1; end
        ST_WWAIT:   if (wait_over) state <= ST_IDLE;
        default:    ;
      endcase
    end
  end

  assign tgt_rst   = (state == ST_PULSE) || (state == ST_DONE);
  assign cmd_ready = (state == ST_IDLE);
  assign busy      = !((state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL));
endmodule

// File: rtl/serprog_host_chk.sv
module serprog_host_chk #(
  parameter int MAX_RETRY = 8,
  parameter int RETRY_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               tgt_sck,
  input logic               tgt_mosi,
  input logic               tgt_rst,
  input logic               sync_ok,
  input logic               sync_fail,
  input logic [RETRY_W-1:0] retry_cnt,
  input logic               busy,
  input logic               done
);
  assert_sck_low_in_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !tgt_sck);

  assert_mosi_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sck && $past(tgt_sck)) |-> $stable(tgt_mosi));

  assert_retry_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RETRY_W'(MAX_RETRY));

  assert_fail_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fail |=> (sync_fail && !tgt_sck && !cmd_ready && !busy));

  assert_ready_needs_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (sync_ok && !busy && !done));

  assert_done_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && tgt_rst && !tgt_sck && !busy));
endmodule

bind serprog_host serprog_host_chk #(.MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .tgt_sck(tgt_sck),
  .tgt_mosi(tgt_mosi), .tgt_rst(tgt_rst), .sync_ok(sync_ok), .sync_fail(sync_fail),
  .retry_cnt(retry_cnt), .busy(busy), .done(done)
);

// File: tb/serprog_host_bench.sv
`timescale 1ns/1ps
module serprog_host_bench;
  localparam int HALF = 3;
  localparam int RSTC = 4;
  localparam int SETC = 20;
  localparam int WRC  = 30;
  localparam int MAXR = 3;
  localparam int RW   = $clog2(MAXR + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'd0;
  logic [11:0] cmd_addr = '0;
  logic [15:0] cmd_word = '0;
  logic        tgt_sck, tgt_mosi, tgt_rst;
  logic        t_miso = 1'b0;
  logic        sync_ok, sync_fail, busy, done;
  logic [RW-1:0] retry_cnt;

  serprog_host #(.HALF_DIV(HALF), .RST_CYC(RSTC), .SETTLE_CYC(SETC), .WRITE_CYC(WRC),
                 .MAX_RETRY(MAXR), .ADDR_W(12), .PAGE_LSB(5)) u_serprog_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_word(cmd_word),
    .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(t_miso), .tgt_rst(tgt_rst),
    .sync_ok(sync_ok), .sync_fail(sync_fail), .retry_cnt(retry_cnt),
    .busy(busy), .done(done));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- monitor and target model (sampled on falling clock edge)
  int cyc, nfr, fbits, sck_age, rst_pulses, bad_n;
  int min_rst_w, min_settle, rst_rise, rst_fall, phase_err, ready_err;
  bit await_rise, pend_end;
  logic [31:0] fshift;
  logic [31:0] cap[128];
  int fr_start[128], fr_end[128];
  logic psck, prst;
  logic [7:0] t_in, t_echo;
  logic [2:0] t_bc;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; nfr = 0; fbits = 0; sck_age = 1; rst_pulses = 0;
      min_rst_w = 1 << 20; min_settle = 1 << 20; rst_rise = 0; rst_fall = 0;
      phase_err = 0; ready_err = 0; await_rise = 0; pend_end = 0; fshift = '0;
      psck = 1'b0; prst = 1'b0; t_in = '0; t_echo = '0; t_bc = '0; t_miso = 1'b0;
    end else begin
      cyc++;
      if (cmd_ready && busy) ready_err++;
      if (tgt_rst && !prst) begin
        rst_pulses++; rst_rise = cyc;
      end
      if (!tgt_rst && prst) begin
        if (cyc - rst_rise < min_rst_w) min_rst_w = cyc - rst_rise;
        rst_fall = cyc; await_rise = 1;
      end
      if (tgt_rst) begin
        t_bc = '0; t_echo = '0; t_in = '0; t_miso = 1'b0;
      end
      if (tgt_sck && !psck) begin
        if (fbits != 0 && sck_age != HALF) phase_err++;
        if (fbits == 0 && nfr < 128) fr_start[nfr] = cyc;
        if (await_rise) begin
          if (cyc - rst_fall < min_settle) min_settle = cyc - rst_fall;
          await_rise = 0;
        end
        fshift = {fshift[30:0], tgt_mosi};
        fbits++;
        t_in = {t_in[6:0], tgt_mosi};
        if (t_bc == 3'd7) t_echo = t_in ^ ((rst_pulses <= bad_n) ? 8'hFF : 8'h00);
        t_bc = t_bc + 3'd1;
        if (fbits == 32) begin
          if (nfr < 128) cap[nfr] = fshift;
          nfr++; fbits = 0; pend_end = 1;
        end
        sck_age = 1;
      end else if (!tgt_sck && psck) begin
        if (sck_age != HALF) phase_err++;
        if (pend_end && nfr <= 128) fr_end[nfr-1] = cyc;
        pend_end = 0;
        t_miso = t_echo[3'd7 - t_bc];
        sck_age = 1;
      end else begin
        sck_age++;
      end
      psck = tgt_sck; prst = tgt_rst;
    end
  end

  // ---------------- stimulus helpers
  logic [31:0] expf[128];
  int nexp;

  task automatic push(input logic [31:0] f);
    expf[nexp] = f; nexp++;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] k, input logic [11:0] a, input logic [15:0] w);
    cmd_kind = k; cmd_addr = a; cmd_word = w; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic load_word(input logic [11:0] a, input logic [15:0] w);
    send(2'd0, a, w);
    push({8'h40, 8'h00, 3'b000, a[4:0], w[7:0]});
    push({8'h48, 8'h00, 3'b000, a[4:0], w[15:8]});
  endtask

  task automatic page_write(input logic [11:0] a);
    send(2'd1, a, 16'h0000);
    push({8'h4C, 4'h0, a[11:8], a[7:5], 5'b00000, 8'h00});
  endtask

  task automatic do_reset(input int bad);
    bad_n = bad;
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(5);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
    summary();
  end

  initial begin
    int frozen;
    nexp = 0;
    // -------- run A: two bad echoes, then in sync
    do_reset(2);
    chk(tgt_rst == 1'b0 && tgt_sck == 1'b0, "R1 reset state lines", {tgt_rst, tgt_sck}, 0);
    chk(!sync_ok && !done && !sync_fail, "R8 reset state status", {sync_ok, done, sync_fail}, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(2);
    chk(!cmd_ready, "R8 not ready before sync", cmd_ready, 0);
    for (int i = 0; i < 20000 && !sync_ok && !sync_fail; i++) @(negedge clk);
    for (int i = 0; i < 3; i++) push(32'hAC530000);
    chk(sync_ok == 1'b1, "R5 sync after third enable", sync_ok, 1);
    chk(retry_cnt == RW'(2), "R6 retry count", retry_cnt, 2);
    chk(rst_pulses == 3, "R6 reset pulse per attempt", rst_pulses, 3);
    chk(min_rst_w >= RSTC, "R1 reset pulse width", min_rst_w, RSTC);
    chk(min_settle >= SETC, "R2 settle before enable", min_settle, SETC);

    // full page sweep, low byte before high byte
    for (int i = 0; i < 32; i++)
      load_word(12'h7E0 + 12'(i), 16'((i * 16'h0123) ^ 16'hA55A));
    page_write(12'h7E7);
    load_word(12'h015, 16'hFFFF);
    load_word(12'h016, 16'h0000);
    page_write(12'h015);
    load_word(12'h81F, 16'h1234);
    send(2'd2, 12'h000, 16'h0000);
    wait_cyc(2);
    chk(done && tgt_rst && !busy, "R12 end releases target", {done, tgt_rst, busy}, 3'b110);
    frozen = nfr;
    wait_cyc(200);
    chk(nfr == frozen && !tgt_sck && tgt_rst, "R12 quiet after end", nfr, frozen);

    chk(nfr == nexp, "R3 instruction count", nfr, nexp);
    chk(fbits == 0, "R3 whole 32-bit instructions", fbits, 0);
    chk(phase_err == 0, "R4 SCK phase widths", phase_err, 0);
    chk(ready_err == 0, "R8 ready never while busy", ready_err, 0);
    for (int i = 0; i < nexp && i < nfr; i++) begin
      if (expf[i][31:24] == 8'hAC)      chk(cap[i] == expf[i], "R5 enable bytes", cap[i], expf[i]);
      else if (expf[i][31:24] == 8'h4C) chk(cap[i] == expf[i], "R10 page write bytes", cap[i], expf[i]);
      else                              chk(cap[i] == expf[i], "R9 load byte order", cap[i], expf[i]);
      if (expf[i][31:24] == 8'h4C && i + 1 < nfr)
        chk(fr_start[i+1] - fr_end[i] >= WRC, "R11 write wait", fr_start[i+1] - fr_end[i], WRC);
    end

    // -------- run B: never in sync
    do_reset(1000);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 20000 && !sync_fail; i++) @(negedge clk);
    chk(sync_fail && !sync_ok, "R7 fail flag", {sync_fail, sync_ok}, 2'b10);
    chk(retry_cnt == RW'(MAXR), "R7 retry at limit", retry_cnt, MAXR);
    chk(nfr == MAXR && rst_pulses == MAXR, "R6 attempts before giving up", nfr, MAXR);
    for (int i = 0; i < nfr && i < 128; i++)
      chk(cap[i] == 32'hAC530000, "R5 full enable on mismatch", cap[i], 32'hAC530000);
    frozen = nfr;
    cmd_valid = 1'b1; cmd_kind = 2'd0;
    wait_cyc(300);
    cmd_valid = 1'b0;
    chk(nfr == frozen && !tgt_sck && !cmd_ready && !busy, "R7 halted after fail",
        {nfr[7:0], tgt_sck, cmd_ready, busy}, {frozen[7:0], 3'b000});
    summary();
  end
endmodule